// File: doc/BRIEF.md
# Paired 8-bit compare-match timer

This block holds two identical 8-bit up-counting timer channels behind one shared register bus. Each channel has a counter, two compare registers (A and B) and a control/status register. It also has one timer output pin. A channel counts only on a one-cycle count-enable pulse, which comes from a clock source selected outside the block. On every count pulse the counter is compared with both compare registers. A match raises a sticky flag and can clear the counter. Match A can also set, reset or toggle the output pin.

Software reaches the registers in two ways. A byte access goes to one channel, picked by `bus_ch`. A word access reaches the same register in both channels at once, with channel 0 in the upper byte. A word access to the counters or to compare A therefore moves a 16-bit pair in a single transfer. Flags are cleared by the usual read-then-write-zero handshake.

Top module: `tmr_pair`

## Requirements
- R1: After reset every counter reads 0x00, both compare registers read 0xFF, the control register reads 0x00 and both output pins are low.
- R2: A counter advances by one on each cycle its count-enable input is high, and holds its value on cycles without a pulse, a software write or a clear.
- R3: A software write to a counter takes priority over both the increment and the clear in the same cycle.
- R4: A compare match happens when count-enable is high and the counter equals a compare register. Match A sets CMFA (control bit 5) and match B sets CMFB (control bit 6).
- R5: Control bits [1:0] pick the clear source: 00 none, 01 match A, 10 match B, 11 the channel's external clear input. With 11, a high external clear zeroes the counter in any cycle; with other codes that input has no effect.
- R6: A count pulse while the counter is 0xFF, with no software counter write, wraps the counter to 0x00 and sets OVF (control bit 4).
- R7: In the cycle software writes a compare register, that register's match is suppressed: no flag, no clear, no pin action.
- R8: Control bits [3:2] set the pin action on match A: 00 no change, 01 drive low, 10 drive high, 11 toggle.
- R9: A flag is cleared only by writing 0 to its bit after a read of the control register that returned it as 1. Writing 1, or writing 0 without such a read, leaves it set.
- R10: If a hardware set and a software clear of a flag fall in the same cycle, the flag stays set.
- R11: With `bus_word` high, a write or read reaches both channels: channel 0 uses bits [15:8] and channel 1 uses bits [7:0]. Register select codes are 0 counter, 1 compare A, 2 compare B, 3 control.
- R12: With `bus_word` low, only channel `bus_ch` is accessed, it uses bits [7:0], and the read data has its upper byte at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 2 | Count-enable pulse per channel |
| ext_clr | input | 2 | External counter clear per channel |
| bus_word | input | 1 | Word access to both channels |
| bus_ch | input | 1 | Channel for a byte access |
| bus_sel | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| tmo | output | 2 | Timer output pin per channel |

## Verification
The bench builds the block with its default 8-bit counter width and the all-ones compare reset value. With that width, an overflow is only two count pulses away after a preload to 0xFE. The compare reset value also gives a free match A at 0xFF on the wrap, which shows that OVF and CMFA are raised together. Because both channels are instantiated, word packing and byte isolation can be seen at the ports. The paired layout also lets one channel run a match-clear scenario while the other runs an overflow scenario.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_W   = 8;
    localparam int NUM_FLG = 3;
    localparam int FLG_OVF  = 0;
    localparam int FLG_CMFA = 1;
    localparam int FLG_CMFB = 2;
    localparam int CTL_FLG_LSB = 4;

    typedef enum logic [1:0] {
        REG_CNT  = 2'd0,
        REG_CMPA = 2'd1,
        REG_CMPB = 2'd2,
        REG_CTL  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CLR_NONE   = 2'd0,
        CLR_MATCHA = 2'd1,
        CLR_MATCHB = 2'd2,
        CLR_EXT    = 2'd3
    } clr_sel_e;

    typedef enum logic [1:0] {
        OUT_HOLD   = 2'd0,
        OUT_LOW    = 2'd1,
        OUT_HIGH   = 2'd2,
        OUT_TOGGLE = 2'd3
    } out_sel_e;

    // Control/status layout: bit7 reserved, [6:4] flags, [3:2] pin action, [1:0] clear source
    typedef struct packed {
        logic                 rsvd;
        logic [NUM_FLG-1:0]   flg;
        out_sel_e             osel;
        clr_sel_e             csel;
    } ctl_t;

    function automatic logic next_pin(input out_sel_e mode, input logic cur);
        case (mode)
            OUT_LOW:    return 1'b0;
            OUT_HIGH:   return 1'b1;
            OUT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_cmp.sv
module tmr_cmp
    import tmr_pkg::*;
#(
    parameter int           W    = TMR_W,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt,
    input  logic         sample,
    output logic [W-1:0] value,
    output logic         match
);

    always_ff @(posedge clk) begin
        if (rst)     value <= INIT;
        else if (wr) value <= wdata;
    end

    // compare is evaluated at count timing and blocked while the register is written
    assign match = sample && !wr && (cnt == value);

    p_cmp_load_r7: assert property (@(posedge clk) disable iff (rst)
        wr |=> value == $past(wdata));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int           W        = TMR_W,
    parameter logic [W-1:0] CMP_INIT = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         ext_clr,
    input  logic         wr,
    input  logic         rd,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         tmo
);

    localparam int CTL_W = $bits(ctl_t);

    logic cnt_wr, cmpa_wr, cmpb_wr, ctl_wr, ctl_rd;
    assign cnt_wr  = wr && (sel == REG_CNT);
    assign cmpa_wr = wr && (sel == REG_CMPA);
    assign cmpb_wr = wr && (sel == REG_CMPB);
    assign ctl_wr  = wr && (sel == REG_CTL);
    assign ctl_rd  = rd && (sel == REG_CTL);

    logic [W-1:0] cnt_q, cmpa_val, cmpb_val;
    logic         match_a, match_b;

    tmr_cmp #(.W(W), .INIT(CMP_INIT)) u_cmp_a (
        .clk(clk), .rst(rst), .wr(cmpa_wr), .wdata(wdata), .cnt(cnt_q),
        .sample(cnt_en), .value(cmpa_val), .match(match_a)
    );

    tmr_cmp #(.W(W), .INIT(CMP_INIT)) u_cmp_b (
        .clk(clk), .rst(rst), .wr(cmpb_wr), .wdata(wdata), .cnt(cnt_q),
        .sample(cnt_en), .value(cmpb_val), .match(match_b)
    );

    clr_sel_e csel_q;
    out_sel_e osel_q;
    logic [NUM_FLG-1:0] flg_q, arm_q, flg_set, flg_clr;
    logic clear_now;

    always_comb begin
        case (csel_q)
            CLR_MATCHA: clear_now = match_a;
            CLR_MATCHB: clear_now = match_b;
            CLR_EXT:    clear_now = ext_clr;
            default:    clear_now = 1'b0;
        endcase
    end

    // counter: software write > clear > increment
    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (cnt_wr)    cnt_q <= wdata;
        else if (clear_now) cnt_q <= '0;
        else if (cnt_en)    cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csel_q <= CLR_NONE;
            osel_q <= OUT_HOLD;
        end else if (ctl_wr) begin
            csel_q <= clr_sel_e'(wdata[1:0]);
            osel_q <= out_sel_e'(wdata[3:2]);
        end
    end

    assign flg_set[FLG_OVF]  = cnt_en && !cnt_wr && (cnt_q == '1);
    assign flg_set[FLG_CMFA] = match_a;
    assign flg_set[FLG_CMFB] = match_b;

    generate
        for (genvar f = 0; f < NUM_FLG; f++) begin : g_flag
            assign flg_clr[f] = ctl_wr && !wdata[CTL_FLG_LSB+f] && arm_q[f];

            always_ff @(posedge clk) begin
                if (rst) begin
                    flg_q[f] <= 1'b0;
                    arm_q[f] <= 1'b0;
                end else begin
                    if (flg_set[f])      flg_q[f] <= 1'b1;
                    else if (flg_clr[f]) flg_q[f] <= 1'b0;

                    if (flg_clr[f] && !flg_set[f]) arm_q[f] <= 1'b0;
                    else if (ctl_rd && flg_q[f])   arm_q[f] <= 1'b1;
                    else if (!flg_q[f])            arm_q[f] <= 1'b0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)          tmo <= 1'b0;
        else if (match_a) tmo <= next_pin(osel_q, tmo);
    end

    ctl_t ctl_view;
    always_comb begin
        ctl_view.rsvd = 1'b0;
        ctl_view.flg  = flg_q;
        ctl_view.osel = osel_q;
        ctl_view.csel = csel_q;
    end

    always_comb begin
        rdata = '0;
        case (sel)
            REG_CNT:  rdata = cnt_q;
            REG_CMPA: rdata = cmpa_val;
            REG_CMPB: rdata = cmpb_val;
            default:  rdata[CTL_W-1:0] = ctl_view;
        endcase
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !cnt_wr && csel_q == CLR_NONE) |=> cnt_q == W'($past(cnt_q) + 1'b1));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !cnt_wr && csel_q != CLR_EXT) |=> $stable(cnt_q));

    p_swwr_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt_q == $past(wdata));

    p_cmfa_r4: assert property (@(posedge clk) disable iff (rst)
        match_a |=> flg_q[FLG_CMFA]);

    p_ovf_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !cnt_wr && cnt_q == '1) |=> flg_q[FLG_OVF]);

    p_suppress_r7: assert property (@(posedge clk) disable iff (rst)
        cmpa_wr |-> !match_a);

    p_tmo_low_r8: assert property (@(posedge clk) disable iff (rst)
        (match_a && osel_q == OUT_LOW) |=> !tmo);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flg_q[FLG_CMFA] && !ctl_wr) |=> flg_q[FLG_CMFA]);

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     cnt_en,
    input  logic [1:0]     ext_clr,
    input  logic           bus_word,
    input  logic           bus_ch,
    input  logic [1:0]     bus_sel,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [2*W-1:0] bus_wdata,
    output logic [2*W-1:0] bus_rdata,
    output logic [1:0]     tmo
);

    localparam int NCH = 2;

    logic [W-1:0] ch_rdata [NCH];
    reg_sel_e     sel;
    assign sel = reg_sel_e'(bus_sel);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic         hit;
            logic [W-1:0] wd;
            assign hit = bus_word || (bus_ch == 1'(i));
            // word access: channel 0 takes the upper byte
            assign wd  = (bus_word && i == 0) ? bus_wdata[2*W-1:W] : bus_wdata[W-1:0];

            tmr_channel #(.W(W)) u_ch (
                .clk(clk), .rst(rst), .cnt_en(cnt_en[i]), .ext_clr(ext_clr[i]),
                .wr(bus_wr && hit), .rd(bus_rd && hit), .sel(sel), .wdata(wd),
                .rdata(ch_rdata[i]), .tmo(tmo[i])
            );
        end
    endgenerate

    assign bus_rdata = bus_word ? {ch_rdata[0], ch_rdata[1]}
                                : {{W{1'b0}}, ch_rdata[bus_ch]};

endmodule

// File: tb/tb_tmr_pair.sv
`timescale 1ns/1ps
module tb_tmr_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cnt_en = '0;
    logic [1:0]  ext_clr = '0;
    logic        bus_word = 1'b0;
    logic        bus_ch = 1'b0;
    logic [1:0]  bus_sel = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  tmo;

    always #2.5 clk = ~clk;

    tmr_pair dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .ext_clr(ext_clr),
        .bus_word(bus_word), .bus_ch(bus_ch), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tmo(tmo)
    );

    localparam logic [1:0] S_CNT = 2'd0, S_CA = 2'd1, S_CB = 2'd2, S_CTL = 2'd3;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [15:0] rd_val;

    typedef struct packed {
        logic        wr;
        logic        word;
        logic        ch;
        logic [1:0]  sel;
        logic [3:0]  req;
        logic [15:0] data;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b0, S_CNT, 4'd1,  16'h0000},  // R1
        '{1'b0, 1'b1, 1'b0, S_CA,  4'd1,  16'hFFFF},  // R1
        '{1'b0, 1'b1, 1'b0, S_CB,  4'd1,  16'hFFFF},  // R1
        '{1'b0, 1'b1, 1'b0, S_CTL, 4'd1,  16'h0000},  // R1
        '{1'b1, 1'b1, 1'b0, S_CNT, 4'd11, 16'h1234},
        '{1'b0, 1'b1, 1'b0, S_CNT, 4'd11, 16'h1234},  // R11
        '{1'b0, 1'b0, 1'b1, S_CNT, 4'd12, 16'h0034},  // R12
        '{1'b0, 1'b0, 1'b0, S_CNT, 4'd12, 16'h0012},  // R12
        '{1'b1, 1'b0, 1'b0, S_CA,  4'd12, 16'hAB56},
        '{1'b0, 1'b1, 1'b0, S_CA,  4'd12, 16'h56FF},  // R12
        '{1'b1, 1'b0, 1'b1, S_CB,  4'd12, 16'hAB77},
        '{1'b0, 1'b1, 1'b0, S_CB,  4'd12, 16'hFF77},  // R12
        '{1'b1, 1'b1, 1'b0, S_CTL, 4'd11, 16'h0D06},
        '{1'b0, 1'b1, 1'b0, S_CTL, 4'd11, 16'h0D06},  // R11
        '{1'b1, 1'b1, 1'b0, S_CTL, 4'd11, 16'h0000},
        '{1'b0, 1'b1, 1'b0, S_CTL, 4'd11, 16'h0000}   // R11
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic word, input logic ch,
                          input logic [1:0] sel, input logic [15:0] data, input logic [1:0] en);
        @(negedge clk);
        bus_wr = wr; bus_rd = ~wr; bus_word = word; bus_ch = ch;
        bus_sel = sel; bus_wdata = data; cnt_en = en;
        #1 rd_val = bus_rdata;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; cnt_en = '0;
    endtask

    task automatic wr_b(input logic ch, input logic [1:0] sel, input logic [7:0] d);
        bus_op(1'b1, 1'b0, ch, sel, {8'h00, d}, 2'b00);
    endtask

    task automatic exp_b(input string req, input logic ch, input logic [1:0] sel, input logic [7:0] e);
        bus_op(1'b0, 1'b0, ch, sel, 16'h0000, 2'b00);
        check(req, rd_val, {8'h00, e});
    endtask

    task automatic pulse(input logic [1:0] m);
        @(negedge clk); cnt_en = m;
        @(negedge clk); cnt_en = '0;
    endtask

    task automatic ext_pulse(input logic [1:0] m);
        @(negedge clk); ext_clr = m;
        @(negedge clk); ext_clr = '0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 tmo", {14'h0, tmo}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            bus_op(VEC[i].wr, VEC[i].word, VEC[i].ch, VEC[i].sel, VEC[i].data, 2'b00);
            if (!VEC[i].wr)
                check($sformatf("R%0d table row %0d", VEC[i].req, i), rd_val, VEC[i].data);
        end

        // R2: counting on enable pulses only, other channel untouched
        bus_op(1'b1, 1'b1, 1'b0, S_CNT, 16'h0000, 2'b00);
        pulse(2'b01); pulse(2'b01); pulse(2'b01);
        exp_b("R2 count", 1'b0, S_CNT, 8'h03);
        exp_b("R2 other ch", 1'b1, S_CNT, 8'h00);
        repeat (5) @(negedge clk);
        exp_b("R2 hold", 1'b0, S_CNT, 8'h03);

        // R3: write beats increment
        bus_op(1'b1, 1'b0, 1'b0, S_CNT, 16'h0040, 2'b01);
        exp_b("R3 write priority", 1'b0, S_CNT, 8'h40);

        // R4 R5 R8: clear on match A, toggle pin
        wr_b(1'b0, S_CTL, 8'h0D);
        wr_b(1'b0, S_CA, 8'h05);
        wr_b(1'b0, S_CNT, 8'h03);
        pulse(2'b01); pulse(2'b01);
        exp_b("R4 no match yet", 1'b0, S_CTL, 8'h0D);
        pulse(2'b01);
        exp_b("R5 match A clear", 1'b0, S_CNT, 8'h00);
        exp_b("R4 CMFA", 1'b0, S_CTL, 8'h2D);
        check("R8 toggle high", {15'h0, tmo[0]}, 16'h0001);

        // R9: writing 1 keeps the flag; unread flag survives write 0
        wr_b(1'b0, S_CTL, 8'h2D);
        exp_b("R9 write one", 1'b0, S_CTL, 8'h2D);
        wr_b(1'b0, S_CB, 8'h01);
        pulse(2'b01); pulse(2'b01);
        wr_b(1'b0, S_CTL, 8'h0D);
        exp_b("R9 unread CMFB kept", 1'b0, S_CTL, 8'h4D);
        wr_b(1'b0, S_CTL, 8'h0D);
        exp_b("R9 CMFB cleared", 1'b0, S_CTL, 8'h0D);

        // R10: set beats clear
        wr_b(1'b0, S_CNT, 8'h05);
        pulse(2'b01);
        check("R8 toggle low", {15'h0, tmo[0]}, 16'h0000);
        exp_b("R10 setup", 1'b0, S_CTL, 8'h2D);
        wr_b(1'b0, S_CNT, 8'h05);
        bus_op(1'b1, 1'b0, 1'b0, S_CTL, 16'h000D, 2'b01);
        exp_b("R10 set wins", 1'b0, S_CTL, 8'h2D);
        check("R8 toggle again", {15'h0, tmo[0]}, 16'h0001);

        // R7: compare write suppresses match
        wr_b(1'b0, S_CTL, 8'h0D);
        exp_b("R9 read-then-zero", 1'b0, S_CTL, 8'h0D);
        wr_b(1'b0, S_CNT, 8'h05);
        bus_op(1'b1, 1'b0, 1'b0, S_CA, 16'h0005, 2'b01);
        exp_b("R7 no clear", 1'b0, S_CNT, 8'h06);
        exp_b("R7 no flag", 1'b0, S_CTL, 8'h0D);
        check("R7 pin held", {15'h0, tmo[0]}, 16'h0001);

        // R8: low, high, hold encodings
        wr_b(1'b0, S_CTL, 8'h05); wr_b(1'b0, S_CNT, 8'h05); pulse(2'b01);
        check("R8 drive low", {15'h0, tmo[0]}, 16'h0000);
        wr_b(1'b0, S_CTL, 8'h09); wr_b(1'b0, S_CNT, 8'h05); pulse(2'b01);
        check("R8 drive high", {15'h0, tmo[0]}, 16'h0001);
        wr_b(1'b0, S_CTL, 8'h01); wr_b(1'b0, S_CNT, 8'h05); pulse(2'b01);
        check("R8 no change", {15'h0, tmo[0]}, 16'h0001);
        exp_b("R5 cleared again", 1'b0, S_CNT, 8'h00);

        // R6: overflow on channel 1 (compare A still 0xFF)
        wr_b(1'b1, S_CTL, 8'h00);
        wr_b(1'b1, S_CNT, 8'hFE);
        pulse(2'b10);
        exp_b("R6 no ovf at FE", 1'b1, S_CTL, 8'h00);
        pulse(2'b10);
        exp_b("R6 wrap", 1'b1, S_CNT, 8'h00);
        exp_b("R6 OVF and CMFA", 1'b1, S_CTL, 8'h30);

        // R5: external clear select
        wr_b(1'b1, S_CTL, 8'h00);
        wr_b(1'b1, S_CNT, 8'h20);
        ext_pulse(2'b10);
        exp_b("R5 ext ignored", 1'b1, S_CNT, 8'h20);
        wr_b(1'b1, S_CTL, 8'h03);
        ext_pulse(2'b10);
        exp_b("R5 ext clear", 1'b1, S_CNT, 8'h00);
        wr_b(1'b1, S_CTL, 8'h02);
        wr_b(1'b1, S_CNT, 8'h77);
        pulse(2'b10);
        exp_b("R5 match B clear", 1'b1, S_CNT, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule